// File: doc/BRIEF.md
# Absolute Time-of-Day Compare Timer

This block keeps a free-running 64-bit time-of-day count that advances by one on every tick. It also holds a 64-bit deadline register. Ticks come from an internal prescaler that divides the core clock by a programmable amount. Software schedules work by absolute time, not by intervals. It writes the time at which the next event is due into the deadline register. On each tick the block compares the freshly incremented time against that deadline. When the time has moved past the deadline, the block raises a level interrupt. In the same action it loads the deadline with all ones, so the alarm disarms itself.

Four commands act on the two registers, and each completes in a single cycle:

- loading the time (the old time is returned),
- loading the deadline (the old deadline is returned),
- a conditional deadline load that only ever moves the deadline earlier and reports whether it swapped,
- reading the time.

Operands and results travel as high and low 32-bit halves. Both halves are captured in the cycle the command starts, so a tick can never tear a value. When a tick and a command share a cycle, the tick is applied first and the command sees the updated state.

Top module: `abs_time_cmp_timer`

## Requirements
- R1: After reset the time is 0, the deadline is all ones, `irq` is 0, `res_done` and `res_flag` are 0, and both result halves are 0.
- R2: A tick occurs once every `tick_div`+1 clock cycles (every cycle when `tick_div` is 0), and each tick adds exactly one to the time. Without a tick or a time load, the time does not change.
- R3: The deadline is evaluated only on a tick, against the incremented time. The alarm fires when time > deadline, and equality does not fire.
- R4: When the alarm fires, `irq` goes to 1 and the deadline becomes all ones. `irq` then stays 1 until a cycle with `irq_ack` = 1 and no new firing. A firing in the same cycle as `irq_ack` keeps `irq` at 1.
- R5: A deadline written below the current time makes the alarm fire on the next tick.
- R6: Opcode 0 (load time) returns the time as it stands after that cycle's tick, then loads the operand into the time.
- R7: Opcode 1 (load deadline) returns the deadline as it stands after that cycle's possible all-ones reload, then loads the operand into the deadline.
- R8: Opcode 2 (conditional deadline) applies only when the operand is strictly below the deadline. In that case it returns the old deadline, loads the operand and returns flag 1. Otherwise the deadline is unchanged, the flag is 0 and the result is 0.
- R9: Opcode 3 (read time) returns the time as it stands after that cycle's tick and changes nothing.
- R10: The operand is {`cmd_hi`,`cmd_lo`}, captured at the edge where `cmd_go` is 1. The result appears as {`res_hi`,`res_lo`} with `res_done` = 1 exactly one cycle later, and `res_flag` is 0 for every opcode other than 2.
- R11: In a cycle with both a tick and a command, the tick is applied first. A deadline write in a firing cycle takes precedence over the all-ones reload, while `irq` is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_div | input | DIV_W | Tick period minus one, in core clock cycles |
| cmd_go | input | 1 | Command start, one cycle per command |
| cmd_op | input | 2 | Opcode: 0 load time, 1 load deadline, 2 conditional deadline, 3 read time |
| cmd_hi | input | HALF_W | Upper half of the operand |
| cmd_lo | input | HALF_W | Lower half of the operand |
| res_done | output | 1 | Result valid, one cycle after `cmd_go` |
| res_flag | output | 1 | Swap indication of the conditional deadline command |
| res_hi | output | HALF_W | Upper half of the returned value |
| res_lo | output | HALF_W | Lower half of the returned value |
| irq | output | 1 | Alarm interrupt, level |
| irq_ack | input | 1 | Clears `irq` |

## Verification
Two functions can fall in the same cycle: a tick with a command, and an alarm firing with a deadline write. The bench sets the prescaler to tick on every cycle and issues a time load directly after another one. The returned old time must then be the first loaded value plus one, which shows the tick went first. It also writes a new deadline in exactly the cycle whose tick carries the time past the old deadline. It then judges that `irq` rises, that the returned deadline is all ones, and that a following read-back of the deadline gives the written value rather than the reload.

// File: rtl/abs_time_cmp_timer.sv
module abs_time_cmp_timer #(
  parameter int HALF_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  tick_div,
  input  logic              cmd_go,
  input  logic [1:0]        cmd_op,
  input  logic [HALF_W-1:0] cmd_hi,
  input  logic [HALF_W-1:0] cmd_lo,
  output logic              res_done,
  output logic              res_flag,
  output logic [HALF_W-1:0] res_hi,
  output logic [HALF_W-1:0] res_lo,
  output logic              irq,
  input  logic              irq_ack
);
  localparam int W = 2 * HALF_W;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [DIV_W-1:0] DONE = {{(DIV_W-1){1'b0}}, 1'b1};
  localparam logic [1:0] OP_LD_TIME = 2'd0;
  localparam logic [1:0] OP_LD_DL   = 2'd1;
  localparam logic [1:0] OP_CAS_DL  = 2'd2;
  localparam logic [1:0] OP_RD_TIME = 2'd3;

  logic [DIV_W-1:0] div_cnt;
  logic [W-1:0]     tod, cmp;
  logic [W-1:0]     tod_nx, cmp_nx, res_nx;
  logic             flag_nx;

  logic         tick;
  logic [W-1:0] tod_t;
  logic         fire;
  logic [W-1:0] cmp_t;
  logic [W-1:0] opnd;

  assign tick  = div_cnt >= tick_div;
  assign tod_t = tick ? tod + ONE : tod;
  assign fire  = tick && (tod_t > cmp);
  assign cmp_t = fire ? '1 : cmp;
  assign opnd  = {cmd_hi, cmd_lo};

  always_comb begin
    tod_nx  = tod_t;
    cmp_nx  = cmp_t;
    res_nx  = '0;
    flag_nx = 1'b0;
    if (cmd_go) begin
      case (cmd_op)
        OP_LD_TIME: begin
          res_nx = tod_t;
          tod_nx = opnd;
        end
        OP_LD_DL: begin
          res_nx = cmp_t;
          cmp_nx = opnd;
        end
        OP_CAS_DL: begin
          if (opnd < cmp_t) begin
            res_nx  = cmp_t;
            cmp_nx  = opnd;
            flag_nx = 1'b1;
          end
        end
        default: res_nx = tod_t;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      tod      <= '0;
      cmp      <= '1;
      irq      <= 1'b0;
      res_done <= 1'b0;
      res_flag <= 1'b0;
      res_hi   <= '0;
      res_lo   <= '0;
    end else begin
      div_cnt  <= tick ? '0 : div_cnt + DONE;
      tod      <= tod_nx;
      cmp      <= cmp_nx;
      res_done <= cmd_go;
      if (fire)
        irq <= 1'b1;
      else if (irq_ack)
        irq <= 1'b0;
      if (cmd_go) begin
        res_hi   <= res_nx[W-1:HALF_W];
        res_lo   <= res_nx[HALF_W-1:0];
        res_flag <= flag_nx;
      end
    end
  end
endmodule

// File: rtl/abs_time_cmp_timer_chk.sv
module abs_time_cmp_timer_chk #(
  parameter int HALF_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_go,
  input logic [1:0]          cmd_op,
  input logic                res_done,
  input logic                res_flag,
  input logic [HALF_W-1:0]   res_hi,
  input logic [HALF_W-1:0]   res_lo,
  input logic                irq,
  input logic                irq_ack,
  input logic [2*HALF_W-1:0] tod,
  input logic [2*HALF_W-1:0] cmp
);
  localparam logic [2*HALF_W-1:0] ONE = {{(2*HALF_W-1){1'b0}}, 1'b1};

  AST_DONE_FOLLOWS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> res_done); // R10
  AST_NO_DONE_WITHOUT_GO: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_go |=> !res_done); // R10
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_go && cmd_op == 2'd0) |=> (tod == $past(tod) || tod == $past(tod) + ONE)); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R4
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && !$past(cmd_go)) |-> (cmp == '1)); // R4
  AST_FLAG_ONLY_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_flag) |-> ($past(cmd_op) == 2'd2)); // R8
  AST_READ_RETURNS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_op == 2'd3) |=> ({res_hi, res_lo} == tod)); // R9
  AST_DL_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_go && (cmd_op == 2'd1 || cmd_op == 2'd2)) |=> ($stable(cmp) || cmp == '1)); // R7
endmodule

bind abs_time_cmp_timer abs_time_cmp_timer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op),
  .res_done(res_done), .res_flag(res_flag), .res_hi(res_hi), .res_lo(res_lo),
  .irq(irq), .irq_ack(irq_ack), .tod(tod), .cmp(cmp)
);

// File: tb/sim_abs_time_cmp_timer.sv
module sim_abs_time_cmp_timer;
  localparam logic [63:0] ONES = '1;
  localparam int NV = 12;
  localparam logic [1:0] V_OP [NV] = '{2'd3, 2'd1, 2'd2, 2'd2, 2'd2, 2'd0,
                                       2'd3, 2'd1, 2'd0, 2'd3, 2'd1, 2'd0};
  localparam logic [63:0] V_ARG [NV] = '{
    64'h0, 64'h100, 64'h200, 64'h80, 64'h80, 64'h1_0000_0005,
    64'h0, 64'hDEAD_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h100, 64'h0, 64'h0,
    64'h1_0000_0005, 64'h80, 64'h1_0000_0005, 64'hFFFF_FFFF_FFFF_FFF0,
    64'hDEAD_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFF0};
  localparam logic V_FLAG [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                                   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam string V_REQ [NV] = '{"R9", "R7", "R8", "R8", "R8", "R6",
                                   "R9", "R7", "R6", "R9", "R7", "R6"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] tick_div = 16'hFFFF;
  logic cmd_go = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [31:0] cmd_hi = '0, cmd_lo = '0;
  logic res_done, res_flag, irq;
  logic [31:0] res_hi, res_lo;
  logic irq_ack = 1'b0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  abs_time_cmp_timer #(.HALF_W(32), .DIV_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .cmd_go(cmd_go),
    .cmd_op(cmd_op), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .res_done(res_done),
    .res_flag(res_flag), .res_hi(res_hi), .res_lo(res_lo), .irq(irq),
    .irq_ack(irq_ack));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [63:0] val);
    cmd_op = op;
    cmd_hi = val[63:32];
    cmd_lo = val[31:0];
    cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic check_res(input string req, input logic [63:0] exp, input logic flg);
    check(req, {63'd0, res_done}, 64'd1);
    check(req, {res_hi, res_lo}, exp);
    check(req, {63'd0, res_flag}, {63'd0, flg});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 done", {63'd0, res_done}, 64'd0);
    check("R1 irq", {63'd0, irq}, 64'd0);
    check("R1 result", {res_hi, res_lo}, 64'd0);
    check("R1 flag", {63'd0, res_flag}, 64'd0);

    // table: no ticks occur, so time moves only by load (R3: no evaluation without tick)
    for (int i = 0; i < NV; i++) begin
      issue(V_OP[i], V_ARG[i]);
      check_res(V_REQ[i], V_EXP[i], V_FLAG[i]);
      check("R3 no tick no irq", {63'd0, irq}, 64'd0);
    end

    // R11 / R2: tick every cycle, tick first in command cycle
    tick_div = 16'd0;
    issue(2'd0, 64'd100);
    check_res("R11 tick before load", 64'd1, 1'b0);
    issue(2'd1, 64'd103);
    check_res("R7 old deadline", ONES, 1'b0);
    @(negedge clk);
    check("R3 below", {63'd0, irq}, 64'd0);
    @(negedge clk);
    check("R3 equal no fire", {63'd0, irq}, 64'd0);
    @(negedge clk);
    check("R3 fire", {63'd0, irq}, 64'd1);
    issue(2'd1, ONES);
    check_res("R4 disarm to ones", ONES, 1'b0);
    check("R4 irq held", {63'd0, irq}, 64'd1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R4 ack clears", {63'd0, irq}, 64'd0);

    // R11: deadline write in firing cycle wins over reload
    issue(2'd0, 64'd200);
    issue(2'd1, 64'd200);
    issue(2'd1, 64'd500);
    check("R11 irq raised", {63'd0, irq}, 64'd1);
    check_res("R11 old is reload", ONES, 1'b0);
    irq_ack = 1'b1;
    issue(2'd1, ONES);
    irq_ack = 1'b0;
    check_res("R11 write kept", 64'd500, 1'b0);
    check("R4 ack", {63'd0, irq}, 64'd0);

    // R5: deadline in the past fires on next tick
    issue(2'd1, 64'd10);
    check("R5 not yet", {63'd0, irq}, 64'd0);
    @(negedge clk);
    check("R5 fired", {63'd0, irq}, 64'd1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;

    // R2 / R9 / R11: back-to-back load then read, then spaced read
    issue(2'd0, 64'd1000);
    issue(2'd3, 64'd0);
    check_res("R11 read after load", 64'd1001, 1'b0);
    repeat (3) @(negedge clk);
    issue(2'd3, 64'd0);
    check_res("R2 per-cycle ticks", 64'd1005, 1'b0);

    // R4: firing and ack in the same cycle keeps irq
    issue(2'd0, 64'd300);
    issue(2'd1, 64'd301);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R4 fire beats ack", {63'd0, irq}, 64'd1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R4 ack after", {63'd0, irq}, 64'd0);

    // R2: divided tick rate, 40 edges at tick_div 3 give 10 ticks
    tick_div = 16'd3;
    issue(2'd0, 64'd0);
    repeat (39) @(negedge clk);
    issue(2'd3, 64'd0);
    check_res("R2 divided rate", 64'd10, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule